// File: doc/BRIEF.md
# Sample-Queue Pulse-Width Modulator

This block drives one pulse-width modulated output from a free-running period counter. Software programs it through four word registers: a control word, a status word, a sample register and a period register. Duty values are written into a four-entry sample queue. The counter takes one queued value as the active compare point at the start of a period. It can hold that value for 1, 2, 4 or 8 consecutive periods before it takes the next one. If the queue is empty when a new value is due, the active value is kept and a sticky flag records the underrun.

The counter advances once per prescaled tick. A period spans the period register value plus two ticks. The value 0xFFFF is treated as 0xFFFE. The output can be true, inverted or held low, and it is always low while the block is disabled. A self-clearing software reset returns every register to its default and empties the queue within four clock cycles. The clock-source field and a group of sideband control bits are stored and read back but have no effect. One module clock drives everything.

Top module: `fifo_pwm`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, the status word (0x04) reads 0, the period register (0x10) reads 0xFFFE and the output is low.
- R2: While enabled, each period lasts (P+2) prescaled ticks, where P is the period register value with 0xFFFF treated as 0xFFFE. The period register reads back the raw value written.
- R3: Control bits [15:4] hold the prescale ratio minus one. The counter advances once every (field+1) clock cycles.
- R4: Control bits [2:1] choose 1, 2, 4 or 8 periods per sample, for codes 0, 1, 2 and 3.
- R5: Control bits [19:18] choose the output mode. Code 0 is high while the counter is below the active sample. Code 1 is the complement of that. Codes 2 and 3 hold the output low.
- R6: Control bit 0 enables the block. While it is clear, the output is low, the counter restarts, and the sample register (0x0C) reads 0. While it is set, the sample register reads the active sample. On enabling, the first queued sample is loaded.
- R7: Writes to offset 0x0C push onto a 4-entry queue whose fill level reads in status bits [2:0]. A write that finds 4 entries (counted before any pop in the same cycle) is dropped and sets status bit 6.
- R8: If the queue is empty when a new sample is due, the last active sample is reused and status bit 3 is set.
- R9: Status bit 4 sets at the end of every period. Status bit 5 sets while the counter equals the active sample. Writing 1 to status bits 3 to 6 clears them, but a flag that sets in the same cycle stays set.
- R10: Writing control bit 3 as 1 empties the queue and restores all register defaults. Bit 3 reads 1 for three cycles and then 0, and register writes are ignored meanwhile.
- R11: Control bits [17:16] and [31:20] are stored and read back, but they do not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
Two collisions matter here, and both come from queue and flag traffic landing on a period boundary. In the first, a sample push falls in the cycle where the counter pops the next sample. In the second, a status clear falls in the cycle where the rollover flag sets. Both are provoked by running a two-tick period with no prescaling while the bench writes the sample register and clear-writes the status word on alternate cycles. The bench model keeps the queue as a plain list, counts fullness before the pop, and lets a setting flag win over its clear. Every clock it is compared against the output, and afterwards against the status and sample reads.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
    // register byte offsets
    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_SMPL = 5'h0C;
    localparam logic [4:0] OFS_PER  = 5'h10;

    // sticky flag positions inside the 4-bit flag vector (status bits 3..6)
    localparam int F_FE  = 0;
    localparam int F_ROV = 1;
    localparam int F_CMP = 2;
    localparam int F_FWE = 3;

    typedef enum logic [1:0] {
        OUT_TRUE  = 2'd0,
        OUT_INV   = 2'd1,
        OUT_LOW_A = 2'd2,
        OUT_LOW_B = 2'd3
    } out_mode_e;
endpackage

// File: rtl/fpwm_fifo.sv
module fpwm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = step(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = step(st_q.rd);
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (!do_push && do_pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] ratio_m1,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = !clear && (cnt_q == ratio_m1);
        cnt_d = (clear || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
    import fpwm_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int PER_W      = 16,
    parameter int PRESC_W    = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);
    localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);
    localparam int CMP_W    = (SAMPLE_W > PER_W) ? SAMPLE_W : PER_W;
    localparam int PRE_LSB  = 4;
    localparam int CLK_LSB  = PRE_LSB + PRESC_W;
    localparam int MODE_LSB = CLK_LSB + 2;
    localparam int AUX_LSB  = MODE_LSB + 2;
    localparam int AUX_W    = DATA_W - AUX_LSB;
    localparam logic [PER_W-1:0] PER_CLAMP = {{(PER_W - 1){1'b1}}, 1'b0};

    typedef struct packed {
        logic                en;
        logic [1:0]          rep_sel;
        logic [PRESC_W-1:0]  pre;
        logic [1:0]          clk_sel;
        out_mode_e           mode;
        logic [AUX_W-1:0]    aux;
        logic [PER_W-1:0]    period;
        logic [3:0]          flags;
        logic [PER_W-1:0]    cnt;
        logic [2:0]          rep;
        logic [SAMPLE_W-1:0] active;
        logic                started;
        logic [1:0]          swr_cnt;
    } st_t;

    function automatic st_t rst_state();
        st_t s;
        s        = '0;
        s.period = PER_CLAMP;
        return s;
    endfunction

    st_t                 st_d, st_q;
    logic                running, tick, below;
    logic [PER_W-1:0]    last_cnt;
    logic [2:0]          reps_m1;
    logic [3:0]          set_f, clr_f;
    logic                fifo_push, fifo_pop, fifo_flush;
    logic [SAMPLE_W-1:0] fifo_head;
    logic [CNT_W-1:0]    fifo_cnt;

    fpwm_prescaler #(.W(PRESC_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!running),
        .ratio_m1 (st_q.pre),
        .tick     (tick)
    );

    fpwm_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (fifo_push),
        .push_data (wdata[SAMPLE_W-1:0]),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_cnt)
    );

    always_comb begin
        running  = st_q.en && st_q.started;
        last_cnt = ((st_q.period == '1) ? PER_CLAMP : st_q.period) + 1'b1;
        case (st_q.rep_sel)
            2'd0:    reps_m1 = 3'd0;
            2'd1:    reps_m1 = 3'd1;
            2'd2:    reps_m1 = 3'd3;
            default: reps_m1 = 3'd7;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        fifo_pop   = 1'b0;
        fifo_push  = 1'b0;
        fifo_flush = 1'b0;
        set_f      = '0;
        clr_f      = '0;
        if (st_q.swr_cnt != '0) begin
            // reset in progress: hold defaults, ignore the bus (R10)
            st_d         = rst_state();
            st_d.swr_cnt = st_q.swr_cnt - 1'b1;
            fifo_flush   = 1'b1;
        end else begin
            if (st_q.en && !st_q.started) begin
                st_d.started = 1'b1;
                st_d.cnt     = '0;
                st_d.rep     = '0;
                if (fifo_cnt != '0) begin
                    fifo_pop    = 1'b1;
                    st_d.active = fifo_head;
                end else begin
                    set_f[F_FE] = 1'b1;
                end
            end else if (running) begin
                if (CMP_W'(st_q.cnt) == CMP_W'(st_q.active)) begin
                    set_f[F_CMP] = 1'b1;
                end
                if (tick) begin
                    if (st_q.cnt == last_cnt) begin
                        st_d.cnt      = '0;
                        set_f[F_ROV]  = 1'b1;
                        if (st_q.rep == reps_m1) begin
                            st_d.rep = '0;
                            if (fifo_cnt != '0) begin
                                fifo_pop    = 1'b1;
                                st_d.active = fifo_head;
                            end else begin
                                set_f[F_FE] = 1'b1;  // underrun: reuse (R8)
                            end
                        end else begin
                            st_d.rep = st_q.rep + 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end else begin
                st_d.started = 1'b0;
                st_d.cnt     = '0;
                st_d.rep     = '0;
            end

            if (wr_en && addr == OFS_SMPL) begin
                if (fifo_cnt == CNT_W'(FIFO_DEPTH)) begin
                    set_f[F_FWE] = 1'b1;
                end else begin
                    fifo_push = 1'b1;
                end
            end
            if (wr_en && addr == OFS_STAT) begin
                clr_f = wdata[6:3];
            end
            st_d.flags = (st_q.flags & ~clr_f) | set_f;
            if (wr_en && addr == OFS_PER) begin
                st_d.period = wdata[PER_W-1:0];
            end
            if (wr_en && addr == OFS_CTRL) begin
                if (wdata[3]) begin
                    st_d         = rst_state();
                    st_d.swr_cnt = 2'd3;
                    fifo_flush   = 1'b1;
                end else begin
                    st_d.en      = wdata[0];
                    st_d.rep_sel = wdata[2:1];
                    st_d.pre     = wdata[PRE_LSB +: PRESC_W];
                    st_d.clk_sel = wdata[CLK_LSB +: 2];
                    st_d.mode    = out_mode_e'(wdata[MODE_LSB +: 2]);
                    st_d.aux     = wdata[AUX_LSB +: AUX_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= rst_state();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        below   = CMP_W'(st_q.cnt) < CMP_W'(st_q.active);
        pwm_out = running && (((st_q.mode == OUT_TRUE) && below) ||
                              ((st_q.mode == OUT_INV) && !below));
        rdata   = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[0]                   = st_q.en;
                rdata[2:1]                 = st_q.rep_sel;
                rdata[3]                   = (st_q.swr_cnt != '0);
                rdata[PRE_LSB +: PRESC_W]  = st_q.pre;
                rdata[CLK_LSB +: 2]        = st_q.clk_sel;
                rdata[MODE_LSB +: 2]       = st_q.mode;
                rdata[AUX_LSB +: AUX_W]    = st_q.aux;
            end
            OFS_STAT: begin
                rdata[CNT_W-1:0] = fifo_cnt;
                rdata[6:3]       = st_q.flags;
            end
            OFS_SMPL: begin
                if (st_q.en) rdata[SAMPLE_W-1:0] = st_q.active;
            end
            OFS_PER: begin
                rdata[PER_W-1:0] = st_q.period;
            end
            default: rdata = '0;
        endcase
    end

    // observation points for the bound checker
    logic             chk_en, chk_off, chk_busy, chk_fwe;
    logic [CNT_W-1:0] chk_cnt;
    assign chk_en   = st_q.en;
    assign chk_off  = st_q.mode[1];
    assign chk_busy = (st_q.swr_cnt != '0);
    assign chk_fwe  = st_q.flags[F_FWE];
    assign chk_cnt  = fifo_cnt;
endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             en,
    input logic             off_mode,
    input logic             busy,
    input logic             fwe_flag,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             wr_en,
    input logic [4:0]       addr,
    input logic             wbit3
);
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);

    a_r5_off_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
        off_mode |-> !pwm_out);

    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    a_r7_full_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h0C && fifo_cnt == CNT_W'(DEPTH) && !busy) |=> fwe_flag);

    a_r10_reset_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h00 && wbit3 && !busy) |=> busy);

    a_r10_queue_empty_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (fifo_cnt == '0 && !pwm_out));
endmodule

bind fifo_pwm fifo_pwm_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_out  (pwm_out),
    .en       (chk_en),
    .off_mode (chk_off),
    .busy     (chk_busy),
    .fwe_flag (chk_fwe),
    .fifo_cnt (chk_cnt),
    .wr_en    (wr_en),
    .addr     (addr),
    .wbit3    (wdata[3])
);

// File: tb/fifo_pwm_tb.sv
module fifo_pwm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = 5'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        pwm_out;

    int nchk = 0;
    int nbad = 0;
    bit cyc_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fifo_pwm u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    // ---------------- behavioural reference ----------------
    int m_en, m_rsel, m_pre, m_clk, m_mode, m_aux, m_per, m_flags;
    int m_cnt, m_rep, m_active, m_started, m_swr, m_pcnt;
    int mq[$];
    int psz, plen, sf, clr;
    bit run, tick;

    task automatic m_defaults();
        m_en = 0; m_rsel = 0; m_pre = 0; m_clk = 0; m_mode = 0; m_aux = 0;
        m_per = 65534; m_flags = 0; m_cnt = 0; m_rep = 0; m_active = 0;
        m_started = 0;
    endtask

    function automatic bit m_out();
        bit lt;
        lt = (m_cnt < m_active);
        return (m_en != 0) && (m_started != 0) &&
               ((m_mode == 0 && lt) || (m_mode == 1 && !lt));
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        logic [31:0] v;
        v = 32'h0;
        case (a)
            5'h00: v = 32'(m_en) | (32'(m_rsel) << 1) | (32'(m_swr != 0) << 3) |
                       (32'(m_pre) << 4) | (32'(m_clk) << 16) | (32'(m_mode) << 18) |
                       (32'(m_aux) << 20);
            5'h04: v = (32'(m_flags) << 3) | 32'(mq.size());
            5'h0C: v = (m_en != 0) ? 32'(m_active) : 32'h0;
            5'h10: v = 32'(m_per);
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_defaults();
            m_swr = 0; m_pcnt = 0;
            mq.delete();
        end else begin
            run  = (m_en != 0) && (m_started != 0);
            tick = run && (m_pcnt == m_pre);
            psz  = mq.size();
            m_pcnt = (!run || tick) ? 0 : m_pcnt + 1;
            if (m_swr != 0) begin
                m_defaults();
                m_swr--;
                mq.delete();
            end else begin
                sf = 0;
                if (m_en != 0 && m_started == 0) begin
                    m_started = 1; m_cnt = 0; m_rep = 0;
                    if (psz > 0) m_active = mq.pop_front(); else sf |= 1;
                end else if (run) begin
                    if (m_cnt == m_active) sf |= 4;
                    if (tick) begin
                        plen = ((m_per > 65534) ? 65534 : m_per) + 2;
                        if (m_cnt == plen - 1) begin
                            m_cnt = 0; sf |= 2;
                            if (m_rep == (1 << m_rsel) - 1) begin
                                m_rep = 0;
                                if (psz > 0) m_active = mq.pop_front(); else sf |= 1;
                            end else begin
                                m_rep++;
                            end
                        end else begin
                            m_cnt++;
                        end
                    end
                end else begin
                    m_started = 0; m_cnt = 0; m_rep = 0;
                end
                if (wr && addr == 5'h0C) begin
                    if (psz >= 4) sf |= 8; else mq.push_back(int'(wdata[15:0]));
                end
                clr = (wr && addr == 5'h04) ? int'(wdata[6:3]) : 0;
                m_flags = (m_flags & ~clr) | sf;
                if (wr && addr == 5'h10) m_per = int'(wdata[15:0]);
                if (wr && addr == 5'h00) begin
                    if (wdata[3]) begin
                        m_defaults(); m_swr = 3; mq.delete();
                    end else begin
                        m_en = int'(wdata[0]); m_rsel = int'(wdata[2:1]);
                        m_pre = int'(wdata[15:4]); m_clk = int'(wdata[17:16]);
                        m_mode = int'(wdata[19:18]); m_aux = int'(wdata[31:20]);
                    end
                end
            end
        end
    end

    // output compared with the model on every clock (R2, R3, R4, R5, R8)
    always @(negedge clk) begin
        if (cyc_on && !done) begin
            nchk++;
            if (pwm_out !== m_out()) begin
                nbad++;
                $display("FAIL R2 output per cycle: actual=%0b expected=%0b", pwm_out, m_out());
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_model(input logic [4:0] a, input string req);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1;
        chk(req, rdata, m_read(a));
    endtask

    task automatic rd_lit(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nbad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc_on = 1'b1;

        // R1 reset values
        rd_lit(5'h00, 32'h0, "R1 ctrl");
        rd_lit(5'h04, 32'h0, "R1 status");
        rd_lit(5'h10, 32'h0000_FFFE, "R1 period");
        chk("R1 out", {31'h0, pwm_out}, 32'h0);

        // R7 fill to full while disabled, fifth write dropped
        for (int i = 0; i < 5; i++) wr_reg(5'h0C, 32'(3 + 2 * i));
        rd_lit(5'h04, 32'h44, "R7 full count and write error");
        rd_lit(5'h0C, 32'h0, "R6 sample reads 0 when disabled");
        // R9 write-one-to-clear
        wr_reg(5'h04, 32'h78);
        rd_lit(5'h04, 32'h04, "R9 flags cleared by writing ones");

        // R2 basic run: period 8 -> 10 ticks, no prescale, one period per sample
        wr_reg(5'h10, 32'd8);
        wr_reg(5'h00, 32'h1);
        idle(25);
        rd_model(5'h0C, "R6 sample reads active value");
        idle(40);
        rd_model(5'h04, "R8 underrun flag after queue drains");
        rd_model(5'h0C, "R8 last sample kept");

        // R3 / R4 prescale ratio 3, four periods per sample
        wr_reg(5'h00, 32'h0);
        wr_reg(5'h0C, 32'd2);
        wr_reg(5'h0C, 32'd6);
        wr_reg(5'h04, 32'h78);
        wr_reg(5'h00, 32'h25);          // pre field 2, repeat code 2, enable
        idle(150);
        rd_model(5'h0C, "R4 sample held over repeated periods");
        idle(250);
        rd_model(5'h04, "R3 status after prescaled run");

        // R5 inverted, then low modes
        wr_reg(5'h00, 32'h4_0025);
        idle(90);
        rd_model(5'h00, "R5 inverted mode readback");
        wr_reg(5'h00, 32'h8_0025);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R5 off mode holds low", {31'h0, pwm_out}, 32'h0);
        end

        // R6 disable forces low
        wr_reg(5'h00, 32'h4_0000);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R6 disabled output low", {31'h0, pwm_out}, 32'h0);
        end

        // R7 / R9 collision: 2-tick periods, pushes and clears on alternate cycles
        wr_reg(5'h10, 32'd0);
        wr_reg(5'h00, 32'h1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wr = 1'b1;
            addr  = (i % 2 == 0) ? 5'h0C : 5'h04;
            wdata = (i % 2 == 0) ? 32'(i % 3) : 32'h78;
        end
        @(negedge clk);
        wr = 1'b0;
        rd_model(5'h04, "R7 push against pop, R9 set beats clear");
        rd_model(5'h0C, "R7 active sample after collisions");

        // R2 clamp: 0xFFFF acts as 0xFFFE
        wr_reg(5'h00, 32'h0);
        wr_reg(5'h04, 32'h78);
        wr_reg(5'h10, 32'h0000_FFFF);
        rd_lit(5'h10, 32'h0000_FFFF, "R2 raw period readback");
        wr_reg(5'h0C, 32'h8000);
        wr_reg(5'h00, 32'h1);
        idle(65560);
        rd_model(5'h04, "R2 rollover after clamped period");

        // R10 software reset
        wr_reg(5'h0C, 32'd5);
        wr_reg(5'h00, 32'h9);
        #1;
        chk("R10 busy bit set", rdata & 32'h8, 32'h8);
        @(negedge clk);
        wr = 1'b1; addr = 5'h10; wdata = 32'd7;   // ignored while busy
        @(negedge clk);
        wr = 1'b0;
        idle(3);
        rd_lit(5'h00, 32'h0, "R10 ctrl cleared");
        rd_lit(5'h10, 32'h0000_FFFE, "R10 period default");
        rd_lit(5'h04, 32'h0, "R10 queue emptied");

        // R11 stored-only fields
        wr_reg(5'h00, 32'hABC3_0000);
        rd_lit(5'h00, 32'hABC3_0000, "R11 stored fields read back");
        chk("R11 no output effect", {31'h0, pwm_out}, 32'h0);

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule